// File: doc/BRIEF.md
# Vector Saturating Pack Unit

This block narrows two vectors of signed 16-bit lanes into a single vector of byte lanes. Every lane is clamped on its own to the range of the chosen output type: a signed byte (-128 to +127) or an unsigned byte (0 to 255). Lanes that are already inside the range pass through unchanged. Lanes outside the range are replaced by the nearest bound. The eight lanes of the first operand fill the upper half of the result, and the eight lanes of the second operand fill the lower half. Lanes are numbered big-endian, so lane 0 is always the most significant.

An operation is started by raising `in_valid` for one cycle with both operands and the mode present. The packed result is registered and appears one cycle later, together with `res_valid`. Whenever any lane of a valid operation clamps, a sticky saturation flag is set. The flag stays set across later clean operations until software writes it through the status write port. If a write and a saturating operation land in the same cycle, the saturation wins. No other condition flags are produced.

Top module: `vsat_pack`

## Requirements
- R1: Half-word lane i of `src_a` (bits [127-16i:112-16i]) drives result byte i, and lane i of `src_b` drives byte 8+i. Byte i occupies `res_data` bits [127-8i:120-8i], so byte 0 is the most significant.
- R2: With `out_unsigned`=0, a lane above +127 yields 0x7F and a lane below -128 yields 0x80.
- R3: With `out_unsigned`=1, a negative lane yields 0x00 and a lane above 255 yields 0xFF. Values from 128 to 255 pass without clamping.
- R4: A lane inside the range of the selected mode produces its own low 8 bits.
- R5: `res_data` and `res_valid` update on the first rising edge after `in_valid` is sampled high. `res_valid` is low after any edge where `in_valid` was low, and `res_data` then keeps its value.
- R6: If any of the 16 lanes of a valid operation clamps, `sat_sticky` is 1 after that edge.
- R7: `sat_sticky` keeps its value across operations that do not clamp. A cycle with `stat_wr_en`=1 loads `stat_wr_data` into it, so writing 0 clears it and writing 1 sets it. Without a valid operation, `in_valid` low leaves it untouched.
- R8: If a clamping operation and a write of 0 occur in the same cycle, `sat_sticky` ends up 1.
- R9: A synchronous active-high `rst` clears `res_data`, `res_valid` and `sat_sticky`.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 128 | First operand, eight signed 16-bit lanes |
| src_b | input | 128 | Second operand, eight signed 16-bit lanes |
| out_unsigned | input | 1 | 0: signed byte output, 1: unsigned byte output |
| stat_wr_en | input | 1 | Write strobe for the saturation flag |
| stat_wr_data | input | 1 | Value written to the saturation flag |
| res_data | output | 128 | Registered packed result, sixteen bytes |
| res_valid | output | 1 | High for one cycle per completed operation |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
Each operation's packed bytes, its valid strobe and the updated saturation flag are all due exactly one rising edge after the cycle in which the operation was driven. Flag writes are due on that same edge. The bench drives on the falling edge and queues one expected item per driven cycle: expected valid, the expected data (the previous value when idle) and the expected flag. A monitor pops one item a quarter period after each rising edge, so every result is compared in the cycle it is due and never early or late.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

   // Output interpretation of a packed lane
   typedef enum logic {
      PACK_SIGNED   = 1'b0,
      PACK_UNSIGNED = 1'b1
   } pack_mode_e;

   // Default geometry of the unit
   localparam int unsigned DEF_LANE_IN_W   = 16;
   localparam int unsigned DEF_LANE_OUT_W  = 8;
   localparam int unsigned DEF_LANES_SRC   = 8;

endpackage

// File: rtl/vsp_lane_clamp.sv
module vsp_lane_clamp
   import vsp_pkg::*;
#(
   parameter int unsigned IN_W          = DEF_LANE_IN_W,
   parameter int unsigned OUT_W         = DEF_LANE_OUT_W,
   parameter bit          RANGE_BY_BITS = 1'b1
) (
   input  logic [IN_W-1:0]  lane_in,
   input  pack_mode_e       mode,
   output logic [OUT_W-1:0] lane_out,
   output logic             lane_sat
);

   localparam int          S_MAX_I = (2 ** (OUT_W - 1)) - 1;
   localparam int          S_MIN_I = -(2 ** (OUT_W - 1));
   localparam int          U_MAX_I = (2 ** OUT_W) - 1;
   localparam logic [OUT_W-1:0] S_MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] S_MIN_V = {1'b1, {(OUT_W-1){1'b0}}};
   localparam logic [OUT_W-1:0] U_MAX_V = {OUT_W{1'b1}};
   localparam logic [OUT_W-1:0] U_MIN_V = {OUT_W{1'b0}};

   logic sign_bit;
   logic s_over;
   logic s_under;
   logic u_over;
   logic u_under;

   assign sign_bit = lane_in[IN_W-1];

   generate
      if (RANGE_BY_BITS) begin : g_bits
         // Range detection from the discarded upper bits
         logic [IN_W-OUT_W:0] s_upper;
         logic                s_fits;
         logic                u_high_any;

         assign s_upper    = lane_in[IN_W-1:OUT_W-1];
         assign s_fits     = (&s_upper) | ~(|s_upper);
         assign u_high_any = |lane_in[IN_W-2:OUT_W];

         assign s_over  = ~s_fits & ~sign_bit;
         assign s_under = ~s_fits &  sign_bit;
         assign u_over  = ~sign_bit & u_high_any;
         assign u_under = sign_bit;
      end else begin : g_cmp
         // Range detection with full-width signed comparators
         int lane_val;

         assign lane_val = int'($signed(lane_in));
         assign s_over   = (lane_val > S_MAX_I);
         assign s_under  = (lane_val < S_MIN_I);
         assign u_over   = (lane_val > U_MAX_I);
         assign u_under  = (lane_val < 0);
      end
   endgenerate

   always_comb begin
      lane_out = lane_in[OUT_W-1:0];
      lane_sat = 1'b0;
      unique case (mode)
         PACK_SIGNED: begin
            if (s_over) begin
               lane_out = S_MAX_V;
               lane_sat = 1'b1;
            end else if (s_under) begin
               lane_out = S_MIN_V;
               lane_sat = 1'b1;
            end
         end
         PACK_UNSIGNED: begin
            if (u_over) begin
               lane_out = U_MAX_V;
               lane_sat = 1'b1;
            end else if (u_under) begin
               lane_out = U_MIN_V;
               lane_sat = 1'b1;
            end
         end
         default: begin
            lane_out = lane_in[OUT_W-1:0];
            lane_sat = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/vsp_pack_array.sv
module vsp_pack_array
   import vsp_pkg::*;
#(
   parameter int unsigned IN_W          = DEF_LANE_IN_W,
   parameter int unsigned OUT_W         = DEF_LANE_OUT_W,
   parameter int unsigned LANES         = DEF_LANES_SRC,
   parameter bit          RANGE_BY_BITS = 1'b1,
   localparam int unsigned SRC_W        = IN_W * LANES,
   localparam int unsigned RES_W        = OUT_W * LANES * 2
) (
   input  logic [SRC_W-1:0] src_hi,
   input  logic [SRC_W-1:0] src_lo,
   input  pack_mode_e       mode,
   output logic [RES_W-1:0] packed_out,
   output logic             any_sat
);

   localparam int unsigned TOTAL = LANES * 2;

   logic [TOTAL-1:0] lane_sat_vec;

   generate
      for (genvar gi = 0; gi < TOTAL; gi++) begin : g_lane
         // Lane gi: first operand for the upper half, second for the lower
         localparam int unsigned SRC_LANE = (gi < LANES) ? gi : gi - LANES;
         localparam int unsigned IN_TOP   = SRC_W - 1 - IN_W * SRC_LANE;
         localparam int unsigned OUT_TOP  = RES_W - 1 - OUT_W * gi;

         logic [IN_W-1:0]  lane_val;
         logic [OUT_W-1:0] lane_res;
         logic             lane_flag;

         if (gi < LANES) begin : g_from_hi
            assign lane_val = src_hi[IN_TOP -: IN_W];
         end else begin : g_from_lo
            assign lane_val = src_lo[IN_TOP -: IN_W];
         end

         vsp_lane_clamp #(
            .IN_W          (IN_W),
            .OUT_W         (OUT_W),
            .RANGE_BY_BITS (RANGE_BY_BITS)
         ) u_clamp (
            .lane_in  (lane_val),
            .mode     (mode),
            .lane_out (lane_res),
            .lane_sat (lane_flag)
         );

         assign packed_out[OUT_TOP -: OUT_W] = lane_res;
         assign lane_sat_vec[gi]             = lane_flag;
      end
   endgenerate

   assign any_sat = |lane_sat_vec;

endmodule

// File: rtl/vsp_result_reg.sv
module vsp_result_reg #(
   parameter int unsigned DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q,
   output logic              q_valid
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q       <= '0;
         q_valid <= 1'b0;
      end else begin
         q_valid <= load;
         if (load) begin
            q <= d;
         end
      end
   end

endmodule

// File: rtl/vsp_sticky.sv
module vsp_sticky (
   input  logic clk,
   input  logic rst,
   input  logic set_pulse,
   input  logic wr_en,
   input  logic wr_data,
   output logic flag
);

   logic flag_written;

   // Software write first, then a saturation event overrides it
   assign flag_written = wr_en ? wr_data : flag;

   always_ff @(posedge clk) begin
      if (rst) begin
         flag <= 1'b0;
      end else begin
         flag <= flag_written | set_pulse;
      end
   end

endmodule

// File: rtl/vsat_pack.sv
module vsat_pack
   import vsp_pkg::*;
#(
   parameter int unsigned LANE_IN_W     = DEF_LANE_IN_W,
   parameter int unsigned LANE_OUT_W    = DEF_LANE_OUT_W,
   parameter int unsigned LANES_PER_SRC = DEF_LANES_SRC,
   parameter bit          RANGE_BY_BITS = 1'b1,
   localparam int unsigned SRC_W        = LANE_IN_W * LANES_PER_SRC,
   localparam int unsigned RES_W        = LANE_OUT_W * LANES_PER_SRC * 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [SRC_W-1:0] src_a,
   input  logic [SRC_W-1:0] src_b,
   input  logic             out_unsigned,
   input  logic             stat_wr_en,
   input  logic             stat_wr_data,
   output logic [RES_W-1:0] res_data,
   output logic             res_valid,
   output logic             sat_sticky
);

   // Elaboration-time parameter checks
   generate
      if (LANE_IN_W < LANE_OUT_W + 2) begin : g_bad_width
         $error("vsat_pack: input lane must be at least two bits wider than output lane");
      end
      if (LANES_PER_SRC < 1) begin : g_bad_lanes
         $error("vsat_pack: at least one lane per operand is required");
      end
   endgenerate

   pack_mode_e       mode_sel;
   logic [RES_W-1:0] packed_next;
   logic             op_sat;
   logic             sat_event;

   assign mode_sel  = pack_mode_e'(out_unsigned);
   assign sat_event = in_valid & op_sat;

   vsp_pack_array #(
      .IN_W          (LANE_IN_W),
      .OUT_W         (LANE_OUT_W),
      .LANES         (LANES_PER_SRC),
      .RANGE_BY_BITS (RANGE_BY_BITS)
   ) u_array (
      .src_hi     (src_a),
      .src_lo     (src_b),
      .mode       (mode_sel),
      .packed_out (packed_next),
      .any_sat    (op_sat)
   );

   vsp_result_reg #(
      .DATA_W (RES_W)
   ) u_result (
      .clk     (clk),
      .rst     (rst),
      .load    (in_valid),
      .d       (packed_next),
      .q       (res_data),
      .q_valid (res_valid)
   );

   vsp_sticky u_sticky (
      .clk       (clk),
      .rst       (rst),
      .set_pulse (sat_event),
      .wr_en     (stat_wr_en),
      .wr_data   (stat_wr_data),
      .flag      (sat_sticky)
   );

endmodule

// File: rtl/vsat_pack_chk.sv
module vsat_pack_chk #(
   parameter int unsigned RES_W = 128,
   parameter int unsigned OUT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             a_top_neg,
   input logic             out_unsigned,
   input logic             stat_wr_en,
   input logic             stat_wr_data,
   input logic [RES_W-1:0] res_data,
   input logic             res_valid,
   input logic             sat_sticky
);

   // R5: a strobe yields a result valid on the next edge
   a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> res_valid);

   // R5: no strobe, no valid, and the result holds
   a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!res_valid && $stable(res_data)));

   // R2: a negative top lane stays negative in signed mode
   a_r2_sign_kept: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !out_unsigned && a_top_neg) |=> res_data[RES_W-1]);

   // R3: a negative top lane becomes zero in unsigned mode
   a_r3_neg_to_zero: assert property (@(posedge clk) disable iff (rst)
      (in_valid && out_unsigned && a_top_neg) |=> (res_data[RES_W-1 -: OUT_W] == '0));

   // R7: the flag holds unless written
   a_r7_sticky_holds: assert property (@(posedge clk) disable iff (rst)
      (sat_sticky && !stat_wr_en) |=> sat_sticky);

   // R7: with no operation, a write of zero clears the flag
   a_r7_clear_works: assert property (@(posedge clk) disable iff (rst)
      (stat_wr_en && !stat_wr_data && !in_valid) |=> !sat_sticky);

   // R6: the flag rises only from an operation or a write of one
   a_r6_rise_cause: assert property (@(posedge clk) disable iff (rst)
      (!sat_sticky && !in_valid && !(stat_wr_en && stat_wr_data)) |=> !sat_sticky);

endmodule

bind vsat_pack vsat_pack_chk #(
   .RES_W (RES_W),
   .OUT_W (LANE_OUT_W)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .in_valid     (in_valid),
   .a_top_neg    (src_a[SRC_W-1]),
   .out_unsigned (out_unsigned),
   .stat_wr_en   (stat_wr_en),
   .stat_wr_data (stat_wr_data),
   .res_data     (res_data),
   .res_valid    (res_valid),
   .sat_sticky   (sat_sticky)
);

// File: tb/vsat_pack_tb.sv
module vsat_pack_tb;

   localparam int CLK_P = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic         out_unsigned = 1'b0;
   logic         stat_wr_en = 1'b0;
   logic         stat_wr_data = 1'b0;
   logic [127:0] res_data;
   logic         res_valid;
   logic         sat_sticky;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [127:0] exp_data   = '0;
   bit           exp_sticky = 1'b0;

   bit           q_v[$];
   logic [127:0] q_d[$];
   bit           q_s[$];
   string        q_tag[$];

   always #(CLK_P/2) clk = ~clk;

   vsat_pack u_dut (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .src_a        (src_a),
      .src_b        (src_b),
      .out_unsigned (out_unsigned),
      .stat_wr_en   (stat_wr_en),
      .stat_wr_data (stat_wr_data),
      .res_data     (res_data),
      .res_valid    (res_valid),
      .sat_sticky   (sat_sticky)
   );

   task automatic check(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [8:0] clamp_ref(logic [15:0] x, bit uns);
      int v;
      v = int'($signed(x));
      if (uns) begin
         if (v < 0)   return {1'b1, 8'h00};
         if (v > 255) return {1'b1, 8'hFF};
      end else begin
         if (v > 127)  return {1'b1, 8'h7F};
         if (v < -128) return {1'b1, 8'h80};
      end
      return {1'b0, x[7:0]};
   endfunction

   function automatic logic [127:0] mk(int l0, int l1, int l2, int l3,
                                       int l4, int l5, int l6, int l7);
      return {16'(l0), 16'(l1), 16'(l2), 16'(l3), 16'(l4), 16'(l5), 16'(l6), 16'(l7)};
   endfunction

   // Driver: one cycle of stimulus, one expected item
   task automatic step(bit v, logic [127:0] a, logic [127:0] b, bit uns,
                       bit we, bit wd, string tag);
      logic [127:0] d;
      bit           sat;
      logic [8:0]   r;
      d   = '0;
      sat = 1'b0;
      for (int i = 0; i < 8; i++) begin
         r = clamp_ref(a[127-16*i -: 16], uns);
         d[127-8*i -: 8] = r[7:0];
         sat |= r[8];
         r = clamp_ref(b[127-16*i -: 16], uns);
         d[63-8*i -: 8] = r[7:0];
         sat |= r[8];
      end
      @(negedge clk);
      in_valid     = v;
      src_a        = a;
      src_b        = b;
      out_unsigned = uns;
      stat_wr_en   = we;
      stat_wr_data = wd;
      exp_sticky   = (we ? wd : exp_sticky) | (v & sat);
      if (v) exp_data = d;
      q_v.push_back(v);
      q_d.push_back(exp_data);
      q_s.push_back(exp_sticky);
      q_tag.push_back(tag);
   endtask

   task automatic idle(string tag);
      step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, tag);
   endtask

   // Monitor: compares each item one edge after it was driven
   always begin
      @(posedge clk);
      #(CLK_P/4);
      if (q_v.size() > 0) begin
         bit           ev;
         logic [127:0] ed;
         bit           es;
         string        tg;
         ev = q_v.pop_front();
         ed = q_d.pop_front();
         es = q_s.pop_front();
         tg = q_tag.pop_front();
         check(res_valid == ev, tg, "res_valid", {127'b0, res_valid}, {127'b0, ev});
         check(res_data == ed, tg, "res_data", res_data, ed);
         check(sat_sticky == es, tg, "sat_sticky", {127'b0, sat_sticky}, {127'b0, es});
      end
   end

   task automatic drain();
      idle("R5 idle");
      while (q_v.size() > 0) @(negedge clk);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 50000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] seed;
      logic [127:0] ra;
      logic [127:0] rb;

      // R9: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(res_valid == 1'b0, "R9", "res_valid after reset", {127'b0, res_valid}, '0);
      check(res_data == '0, "R9", "res_data after reset", res_data, '0);
      check(sat_sticky == 1'b0, "R9", "sat_sticky after reset", {127'b0, sat_sticky}, '0);
      rst = 1'b0;

      // R4 R1: in-range signed lanes pass through, no flag
      step(1'b1, mk(0, 1, -1, 127, -128, 5, -5, 100),
                 mk(2, -2, 64, -64, 3, -3, 126, -127), 1'b0, 1'b0, 1'b0, "R4 R1 in-range");
      // R1: distinct lane values show the ordering
      step(1'b1, mk(16'h11, 16'h22, 16'h33, 16'h44, 16'h55, 16'h66, 16'h77, 16'h08),
                 mk(16'h09, 16'h1A, 16'h2B, 16'h3C, 16'h4D, 16'h5E, 16'h6F, 16'h70),
                 1'b0, 1'b0, 1'b0, "R1 ordering");
      // R5: idle cycles hold the data, valid low
      idle("R5 hold");
      idle("R5 hold");
      // R2 R6: signed clamping sets the flag
      step(1'b1, mk(128, 300, -129, 32767, -32768, 127, -128, 0),
                 mk(-200, 200, 1000, -1000, 1, 2, 3, 4), 1'b0, 1'b0, 1'b0, "R2 R6 signed clamp");
      // R7: clean operation keeps the flag
      step(1'b1, mk(1, 2, 3, 4, 5, 6, 7, 8), mk(9, 10, 11, 12, 13, 14, 15, 16),
                 1'b0, 1'b0, 1'b0, "R7 sticky holds");
      // R7: write of zero clears
      step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, "R7 clear");
      // R3: unsigned lanes in 128..255 do not clamp
      step(1'b1, mk(128, 200, 255, 0, 1, 129, 254, 100),
                 mk(130, 140, 150, 160, 170, 180, 190, 250), 1'b1, 1'b0, 1'b0, "R3 unsigned in-range");
      // R3 R6: unsigned clamping at both ends
      step(1'b1, mk(-1, 256, -32768, 32767, 255, 0, -2, 300),
                 mk(1, 2, 3, 4, 5, 6, 7, 8), 1'b1, 1'b0, 1'b0, "R3 R6 unsigned clamp");
      // R7: clear again, then write one sets
      step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, "R7 clear");
      step(1'b0, '0, '0, 1'b0, 1'b1, 1'b1, "R7 write one");
      step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, "R7 clear");
      // R8: saturation beats a simultaneous clear
      step(1'b1, mk(1, 2, 3, 4, 5, 6, 7, 8), mk(1, 2, 3, 4, 5, 6, 7, 999),
                 1'b0, 1'b1, 1'b0, "R8 sat wins");
      // R6: only the last lane of the second operand clamps
      step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, "R7 clear");
      step(1'b1, mk(1, 2, 3, 4, 5, 6, 7, 8), mk(1, 2, 3, 4, 5, 6, 7, -129),
                 1'b0, 1'b0, 1'b0, "R6 single lane");
      // R2 R3: same operands in both modes, back to back
      step(1'b1, mk(-5, 150, 0, 127, -128, 255, 256, -1), mk(0, 0, 0, 0, 0, 0, 0, 0),
                 1'b0, 1'b0, 1'b0, "R2 mode signed");
      step(1'b1, mk(-5, 150, 0, 127, -128, 255, 256, -1), mk(0, 0, 0, 0, 0, 0, 0, 0),
                 1'b1, 1'b0, 1'b0, "R3 mode unsigned");

      // Pseudo-random lanes with small and large magnitudes
      seed = 32'h1F2E3D4C;
      for (int k = 0; k < 40; k++) begin
         for (int i = 0; i < 8; i++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            ra[127-16*i -: 16] = seed[9] ? {{7{seed[8]}}, seed[8:0]} : seed[15:0];
            rb[127-16*i -: 16] = seed[25] ? {{7{seed[24]}}, seed[24:16]} : seed[31:16];
         end
         step(1'b1, ra, rb, seed[3], seed[4] & seed[5], 1'b0, "R1 R2 R3 R6 mixed");
      end
      drain();

      // R9: reset during operation clears everything
      step(1'b1, mk(500, 1, 1, 1, 1, 1, 1, 1), mk(1, 1, 1, 1, 1, 1, 1, 1),
                 1'b0, 1'b0, 1'b0, "R6 before reset");
      drain();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(res_valid == 1'b0, "R9", "res_valid mid reset", {127'b0, res_valid}, '0);
      check(res_data == '0, "R9", "res_data mid reset", res_data, '0);
      check(sat_sticky == 1'b0, "R9", "sat_sticky mid reset", {127'b0, sat_sticky}, '0);
      rst        = 1'b0;
      exp_data   = '0;
      exp_sticky = 1'b0;
      step(1'b1, mk(7, 7, 7, 7, 7, 7, 7, 7), mk(-7, -7, -7, -7, -7, -7, -7, -7),
                 1'b0, 1'b0, 1'b0, "R4 after reset");
      drain();

      summary();
   end

endmodule